// File: doc/BRIEF.md
# Run-Time Rate Polyphase FIR Decimator

This block lowers the sample rate of a 16-bit two's-complement stream by a power of two between 1 and 16. It builds one FIR datapath, not a bank of parallel branches. A 4-bit phase accumulator advances by a programmable step on every accepted sample. Its value selects which polyphase slice of a 64-entry prototype table feeds the taps. A large step visits few phases and gives a low rate. A small step visits every phase and gives rate 16.

Each tap owns an accumulator that collects its products over one input block. When the phase accumulator carries out, the tap sums are combined into one output word. Each later tap adds in the partial sum it carried from the block before. The word is then rounded, saturated and presented with a one-cycle valid strobe. The accumulators clear on the same edge. A single control word sets the rate, a right shift applied to every product before accumulation, and a right shift applied to the combined output. A new control word is held aside and only becomes active when the current block closes.

Top module: `poly_decim`

## Requirements
- R1: While reset is low and on the first cycle after it, out_valid is 0 and out_data is 0. After reset, the block decimates by 1 with both shifts 0 until a control word becomes active.
- R2: Control word fields: bits [2:0] hold a rate code k, giving decimation 2^k and phase step 16>>k. Codes 5 to 7 act as code 4. Bits [6:4] give the product shift and bits [12:8] give the output shift. All other bits have no effect.
- R3: Exactly one output is produced per 2^k accepted samples. out_valid is high for one cycle, in the cycle after the clock edge that accepts the last sample of a block. out_data keeps its value while out_valid is low.
- R4: The prototype coefficient for index n (0 to 63) is 64*t(n) - 256. Here t(n) = n+1 for n < 32 and t(n) = 64-n otherwise.
- R5: Number the samples of block b as x_b[q], q = 0 to R-1, in arrival order. Let P_j(b) be the sum over q of floor(x_b[q] * h[16j + q*16/R] / 2^ps), for taps j = 0 to 3. The unscaled result is y(b) = sum over j of P_j(b-j). Blocks before the first one count as zero.
- R6: The output is y shifted right by the output shift s, rounded half up by adding 2^(s-1) first when s > 0, then saturated to the range -32768 to 32767.
- R7: A written control word becomes active at the next block end. Every sample up to and including that block's last one, and that block's output, use the previous settings. A later write before the block end replaces an earlier one.
- R8: Cycles with in_valid low do not advance the phase, do not produce an output and leave out_data unchanged.
- R9: At decimation 1 every accepted sample produces an output on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Input sample, two's complement |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 16 | Control word |
| out_valid | output | 1 | One-cycle output strobe |
| out_data | output | 16 | Decimated sample, rounded and saturated |

## Verification
The bench builds the block with its defaults: 16 phases, 4 taps and 16-bit coefficients. With these values every rate code from 0 to 7 can be reached, including the three codes that clamp to decimation 16. The 39-bit combined sum can exceed the output range by a wide margin, so full-scale blocks at both signs drive the saturation limits. Writes placed partway through a block, and repeated before its end, show that each block keeps the settings it started with.

// File: rtl/pdec_pkg.sv
`timescale 1ns/1ps
package pdec_pkg;
   localparam int CFG_W    = 16;
   localparam int RATE_LSB = 0;
   localparam int RATE_W   = 3;
   localparam int PSH_LSB  = 4;
   localparam int PSH_W    = 3;
   localparam int OSH_LSB  = 8;
   localparam int OSH_W    = 5;

   typedef struct packed {
      logic [OSH_W-1:0]  osh;
      logic [PSH_W-1:0]  psh;
      logic [RATE_W-1:0] rate;
   } cfg_t;

   // unpack a control word; rate codes above the largest supported one clamp
   function automatic cfg_t cfg_decode(input logic [CFG_W-1:0] w, input int max_code);
      cfg_t c;
      c.rate = w[RATE_LSB +: RATE_W];
      c.psh  = w[PSH_LSB +: PSH_W];
      c.osh  = w[OSH_LSB +: OSH_W];
      if (int'(c.rate) > max_code) c.rate = RATE_W'(max_code);
      return c;
   endfunction

   // triangular prototype with a negative offset
   function automatic int proto_tap(input int n, input int ntot, input int cstep, input int cofs);
      int tri_v;
      tri_v = (n < ntot / 2) ? n + 1 : ntot - n;
      return tri_v * cstep - cofs;
   endfunction
endpackage

// File: rtl/pdec_phase.sv
`timescale 1ns/1ps
module pdec_phase
   import pdec_pkg::*;
#(
   parameter int NPH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [$clog2(NPH)-1:0] phase,
   output logic             rollover,
   output cfg_t             act_cfg
);
   localparam int PW = $clog2(NPH);

   cfg_t          pend_cfg;
   logic [PW:0]   step;
   logic [PW:0]   nxt;

   assign step     = (PW+1)'(NPH) >> act_cfg.rate;
   assign nxt      = {1'b0, phase} + step;
   assign rollover = in_valid & nxt[PW];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= '0;
         pend_cfg <= '0;
         act_cfg  <= '0;
      end else begin
         if (cfg_we)   pend_cfg <= cfg_decode(cfg_wdata, PW);
         if (in_valid) phase    <= nxt[PW-1:0];
         if (rollover) act_cfg  <= pend_cfg;
      end
   end
endmodule

// File: rtl/pdec_coef.sv
`timescale 1ns/1ps
module pdec_coef
   import pdec_pkg::*;
#(
   parameter int NPH   = 16,
   parameter int TAPS  = 4,
   parameter int CW    = 16,
   parameter int CSTEP = 64,
   parameter int COFS  = 256
) (
   input  logic [$clog2(NPH)-1:0] phase,
   output logic signed [CW-1:0]   coef [TAPS]
);
   localparam int NTOT = NPH * TAPS;
   localparam int NIW  = $clog2(NTOT);

   logic signed [CW-1:0] tbl [NTOT];

   for (genvar n = 0; n < NTOT; n++) begin : g_tbl
      assign tbl[n] = CW'(proto_tap(n, NTOT, CSTEP, COFS));
   end

   // tap j reads the j-th stride of the prototype at the current phase
   for (genvar j = 0; j < TAPS; j++) begin : g_sel
      assign coef[j] = tbl[NIW'(j * NPH) + NIW'(phase)];
   end
endmodule

// File: rtl/pdec_taps.sv
`timescale 1ns/1ps
module pdec_taps #(
   parameter int DW   = 16,
   parameter int CW   = 16,
   parameter int TAPS = 4,
   parameter int AW   = 39,
   parameter int PSW  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 rollover,
   input  logic signed [DW-1:0] in_data,
   input  logic [PSW-1:0]       psh,
   input  logic signed [CW-1:0] coef [TAPS],
   output logic signed [AW-1:0] total
);
   localparam int PRW = DW + CW;

   logic signed [AW-1:0] acc_q   [TAPS];
   logic signed [AW-1:0] carry_q [TAPS-1];
   logic signed [AW-1:0] sum     [TAPS];
   logic signed [AW-1:0] blk     [TAPS];

   for (genvar j = 0; j < TAPS; j++) begin : g_tap
      logic signed [PRW-1:0] prod;
      assign prod   = in_data * coef[j];
      assign sum[j] = acc_q[j] + AW'(prod >>> psh);
      if (j == TAPS - 1) begin : g_last
         assign blk[j] = sum[j];
      end else begin : g_mid
         assign blk[j] = sum[j] + carry_q[j];
      end
   end

   assign total = blk[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < TAPS; k++)     acc_q[k]   <= '0;
         for (int k = 0; k < TAPS - 1; k++) carry_q[k] <= '0;
      end else if (in_valid) begin
         for (int k = 0; k < TAPS; k++) acc_q[k] <= rollover ? '0 : sum[k];
         if (rollover) begin
            for (int k = 0; k < TAPS - 1; k++) carry_q[k] <= blk[k+1];
         end
      end
   end
endmodule

// File: rtl/pdec_out.sv
`timescale 1ns/1ps
module pdec_out #(
   parameter int AW    = 39,
   parameter int DW    = 16,
   parameter int OSW   = 5,
   parameter int ROUND = 1
) (
   input  logic signed [AW-1:0] total,
   input  logic [OSW-1:0]       osh,
   output logic signed [DW-1:0] y
);
   localparam int XW = AW + 1;
   localparam logic signed [XW-1:0] HI = XW'((64'sd1 <<< (DW - 1)) - 64'sd1);
   localparam logic signed [XW-1:0] LO = -HI - XW'(1);

   logic signed [XW-1:0] wide;
   logic signed [XW-1:0] bias;
   logic signed [XW-1:0] shifted;

   assign wide = XW'(total);

   if (ROUND != 0) begin : g_rnd
      assign bias = (osh == '0) ? '0 : (XW'(1) << (osh - 1'b1));
   end else begin : g_trunc
      assign bias = '0;
   end

   always_comb begin
      shifted = (wide + bias) >>> osh;
      if (shifted > HI)      y = HI[DW-1:0];
      else if (shifted < LO) y = LO[DW-1:0];
      else                   y = shifted[DW-1:0];
   end
endmodule

// File: rtl/poly_decim.sv
`timescale 1ns/1ps
module poly_decim
   import pdec_pkg::*;
#(
   parameter int DW    = 16,
   parameter int NPH   = 16,
   parameter int TAPS  = 4,
   parameter int CW    = 16,
   parameter int CSTEP = 64,
   parameter int COFS  = 256,
   parameter int ROUND = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_data,
   input  logic                 cfg_we,
   input  logic [CFG_W-1:0]     cfg_wdata,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_data
);
   localparam int PW = $clog2(NPH);
   localparam int AW = DW + CW + PW + $clog2(TAPS) + 1;

   if (NPH < 2 || (NPH & (NPH - 1)) != 0) begin : g_chk_nph
      $error("poly_decim: NPH must be a power of two, at least 2");
   end
   if (PW > (1 << RATE_W) - 1) begin : g_chk_code
      $error("poly_decim: rate field too narrow for NPH");
   end
   if (TAPS < 2) begin : g_chk_taps
      $error("poly_decim: TAPS must be at least 2");
   end
   if (DW < 2 || DW > 31 || CW < 2) begin : g_chk_w
      $error("poly_decim: data or coefficient width out of range");
   end
   if ((NPH * TAPS / 2) * CSTEP - COFS >= (1 << (CW - 1)) || COFS >= (1 << (CW - 1))) begin : g_chk_coef
      $error("poly_decim: prototype does not fit the coefficient width");
   end
   if ((1 << OSH_W) - 1 >= AW) begin : g_chk_osh
      $error("poly_decim: output shift range exceeds sum width");
   end

   logic [PW-1:0]         phase;
   logic                  rollover;
   cfg_t                  act_cfg;
   logic [RATE_W-1:0]     act_rate;
   logic signed [CW-1:0]  coef [TAPS];
   logic signed [AW-1:0]  total;
   logic signed [DW-1:0]  y;

   assign act_rate = act_cfg.rate;

   pdec_phase #(.NPH(NPH)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .phase     (phase),
      .rollover  (rollover),
      .act_cfg   (act_cfg)
   );

   pdec_coef #(.NPH(NPH), .TAPS(TAPS), .CW(CW), .CSTEP(CSTEP), .COFS(COFS)) u_coef (
      .phase (phase),
      .coef  (coef)
   );

   pdec_taps #(.DW(DW), .CW(CW), .TAPS(TAPS), .AW(AW), .PSW(PSH_W)) u_taps (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .rollover (rollover),
      .in_data  (in_data),
      .psh      (act_cfg.psh),
      .coef     (coef),
      .total    (total)
   );

   pdec_out #(.AW(AW), .DW(DW), .OSW(OSH_W), .ROUND(ROUND)) u_out (
      .total (total),
      .osh   (act_cfg.osh),
      .y     (y)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= rollover;
         if (rollover) out_data <= y;
      end
   end
endmodule

// File: rtl/poly_decim_chk.sv
`timescale 1ns/1ps
module poly_decim_chk #(
   parameter int NPH = 16,
   parameter int DW  = 16,
   parameter int RW  = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 out_valid,
   input logic signed [DW-1:0] out_data,
   input logic [RW-1:0]        act_rate
);
   localparam int CNTW = $clog2(NPH) + 2;

   logic [CNTW-1:0] cnt;
   logic [RW-1:0]   rate_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         rate_q <= '0;
      end else begin
         rate_q <= act_rate;
         if (out_valid)     cnt <= in_valid ? CNTW'(1) : '0;
         else if (in_valid) cnt <= cnt + 1'b1;
      end
   end

   assert_valid_after_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));
   assert_hold_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data));
   assert_block_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (cnt == (CNTW'(1) << rate_q)));
   assert_switch_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (act_rate != $past(act_rate)) |-> out_valid);
   assert_every_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && act_rate == '0) |=> out_valid);
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_rate_clamped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      act_rate <= RW'($clog2(NPH)));
endmodule

bind poly_decim poly_decim_chk #(.NPH(NPH), .DW(DW), .RW(pdec_pkg::RATE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_data  (out_data),
   .act_rate  (act_rate)
);

// File: tb/sim_poly_decim.sv
`timescale 1ns/1ps
module sim_poly_decim;
   localparam int DW = 16, NPH = 16, TAPS = 4;

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, cfg_we = 1'b0;
   logic signed [DW-1:0] in_data = '0;
   logic [15:0] cfg_wdata = '0;
   logic out_valid;
   logic signed [DW-1:0] out_data;

   always #2.5 clk = ~clk;

   poly_decim u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_data(out_data)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   string tag = "R1";

   int p_rate = 0, p_psh = 0, p_osh = 0;
   int a_rate = 0, a_psh = 0, a_osh = 0;
   int m_q = 0;
   longint blk_x [NPH];
   longint hist [TAPS][TAPS];
   longint m_last = 0;

   function automatic longint ref_coef(int n);   // R4
      int t;
      t = (n < 32) ? n + 1 : 64 - n;
      return longint'(64 * t - 256);
   endfunction

   function automatic longint ref_scale(longint v, int s);   // R6
      longint r;
      r = v;
      if (s > 0) r = (r + (64'sd1 <<< (s - 1))) >>> s;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      return r;
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic cyc(bit v, logic signed [DW-1:0] x);
      bit     ev;
      longint ed;
      longint p [TAPS];
      int     r;
      in_valid = v;
      in_data  = x;
      ev = 0;
      ed = m_last;
      if (v) begin
         r = 1 << a_rate;
         blk_x[m_q] = longint'(x);
         m_q++;
         if (m_q == r) begin
            for (int j = 0; j < TAPS; j++) begin
               p[j] = 0;
               for (int q = 0; q < r; q++)
                  p[j] += (blk_x[q] * ref_coef(16 * j + q * (NPH / r))) >>> a_psh;
            end
            for (int j = TAPS - 1; j > 0; j--) hist[j] = hist[j-1];
            hist[0] = p;
            ed = 0;
            for (int j = 0; j < TAPS; j++) ed += hist[j][j];
            ed = ref_scale(ed, a_osh);
            ev = 1;
            m_q = 0;
            a_rate = p_rate; a_psh = p_psh; a_osh = p_osh;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      if (!v) chk(out_valid == 1'b0, "R8", longint'(out_valid), 0);
      else if (r == 1) chk(out_valid == ev, "R9", longint'(out_valid), longint'(ev));
      else chk(out_valid == ev, "R3", longint'(out_valid), longint'(ev));
      if (ev) chk(longint'(out_data) == ed, tag, longint'(out_data), ed);
      else chk(longint'(out_data) == m_last, v ? "R3" : "R8", longint'(out_data), m_last);
      m_last = ed;
   endtask

   task automatic wr(logic [15:0] w);
      cfg_we = 1'b1;
      cfg_wdata = w;
      p_rate = (w[2:0] > 3'd4) ? 4 : int'(w[2:0]);   // R2
      p_psh  = int'(w[6:4]);
      p_osh  = int'(w[12:8]);
      @(negedge clk);
      cfg_we = 1'b0;
      chk(out_valid == 1'b0, "R8", longint'(out_valid), 0);
   endtask

   function automatic logic [15:0] mkcfg(int code, int ps, int os);
      logic [15:0] w;
      w = 16'($urandom);
      w[2:0]  = 3'(code);
      w[6:4]  = 3'(ps);
      w[12:8] = 5'(os);
      return w;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int j = 0; j < TAPS; j++)
         for (int k = 0; k < TAPS; k++) hist[j][k] = 0;
      repeat (4) @(negedge clk);
      chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
      chk(out_data == '0, "R1", longint'(out_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
      chk(out_data == '0, "R1", longint'(out_data), 0);

      // R1 / R9: default decimation by one
      tag = "R1";
      cyc(1, 16'sd1000);
      cyc(1, -16'sd2000);
      cyc(0, 16'sd0);
      cyc(1, 16'sd32767);
      cyc(1, -16'sd32768);

      // R4: impulses at each position of a rate-4 block
      tag = "R4";
      wr(mkcfg(2, 0, 0));
      for (int i = 0; i < 20; i++) cyc(1, 16'sd0);
      for (int pos = 0; pos < 4; pos++) begin
         for (int q = 0; q < 4; q++) cyc(1, (q == pos) ? 16'sd1 : 16'sd0);
         for (int i = 0; i < 16; i++) cyc(1, 16'sd0);
      end

      // R5 / R2 / R8: every rate code, random shifts, ignored bits, idle gaps
      tag = "R5";
      for (int code = 0; code < 8; code++) begin
         wr(mkcfg(code, $urandom_range(0, 7), $urandom_range(0, 20)));
         for (int i = 0; i < 200; i++) begin
            if ($urandom_range(0, 3) == 0) cyc(0, 16'($urandom));
            if ($urandom_range(0, 4) == 0) cyc(1, ($urandom_range(0, 1) != 0) ? 16'sh7fff : 16'sh8000);
            else cyc(1, 16'($urandom));
         end
      end
      tag = "R2";
      wr(mkcfg(7, 0, 10));
      for (int i = 0; i < 48; i++) cyc(1, 16'($urandom));

      // R6: saturation at both limits, then rounding
      tag = "R6";
      wr(mkcfg(4, 0, 0));
      for (int i = 0; i < 96; i++) cyc(1, 16'sh7fff);
      for (int i = 0; i < 96; i++) cyc(1, 16'sh8000);
      wr(mkcfg(4, 0, 17));
      for (int i = 0; i < 80; i++) cyc(1, 16'($urandom));

      // R7: writes land mid block, twice before the block end
      tag = "R7";
      wr(mkcfg(3, 1, 4));
      for (int i = 0; i < 11; i++) cyc(1, 16'($urandom));
      wr(mkcfg(0, 3, 2));
      cyc(1, 16'sd12345);
      wr(mkcfg(1, 2, 6));
      for (int i = 0; i < 30; i++) cyc(1, 16'($urandom));
      wr(mkcfg(4, 0, 12));
      cyc(1, -16'sd700);
      wr(mkcfg(2, 5, 1));
      for (int i = 0; i < 40; i++) cyc(1, 16'($urandom));

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule